// File: doc/BRIEF.md
# DS3 Receive Overhead Serial Port

This block sits behind a DS3 receive framer. It takes the framed receive bit stream and produces two views of it. The first view is a full-rate copy of the data. It comes with a one-cycle indicator that flags each overhead bit and a one-cycle marker that flags the start of each M-frame. The second view is a narrow port that carries only the overhead bits. It has its own sample enable, which acts as a rising-edge clock for the external receiver, and a frame marker that identifies the first X-bit.

The framer supplies four inputs: the data bit, a per-bit strobe, an alignment flag, and the bit's index within the 4760-bit M-frame. An M-frame holds 56 blocks of 85 bits, and bit 0 of each block is overhead. Index 0 is the first X-bit. The block does not search for framing, detect alarms or process PLCP. It only derives timing markers and serialises the overhead bits.

Top module: `rxoh_port`

## Requirements
- R1: `serData` takes the value of `inBit` one clock after each cycle where `inStrobe` is high. It keeps that value until the next strobe.
- R2: `ohInd` is high for exactly one clock, the clock after a strobe whose `inBitIdx` is a multiple of 85 (0, 85, …, 4675) while `inLocked` is high. It is low in every other cycle.
- R3: `frameStart` is high for exactly one clock, the clock after a locked strobe with `inBitIdx` equal to 0. It is always accompanied by `ohInd` in that same cycle.
- R4: For a locked overhead strobe, `ohData` takes the bit one clock after the strobe. `ohClkEn` then pulses for one clock a further cycle later, and `ohData` holds steady across that pulse.
- R5: A locked M-frame yields exactly 56 `ohClkEn` pulses. They carry the overhead bits in the order in which the bits arrived.
- R6: When `ohClkEn` samples the bit from index 0, `ohFrame` is high. On every other `ohClkEn` pulse, `ohFrame` is low.
- R7: In any cycle that follows a cycle with `inLocked` low, `ohInd`, `frameStart` and `ohClkEn` are low. Strobes taken while unlocked produce no `ohClkEn` pulse. `serData` still follows the input in this state.
- R8: While `rstN` is low, every output is 0.
- R9: When strobes are spaced by idle cycles, no indicator fires in a cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Received data bit |
| inStrobe | input | 1 | Marks a cycle that carries a new bit |
| inLocked | input | 1 | Framer alignment present |
| inBitIdx | input | 13 | Bit position within the M-frame, 0 to 4759 |
| serData | output | 1 | Pass-through data bit |
| ohInd | output | 1 | Overhead bit is on `serData` |
| frameStart | output | 1 | First X-bit is on `serData` |
| ohData | output | 1 | Overhead data bit |
| ohClkEn | output | 1 | Overhead sample enable (rising edge) |
| ohFrame | output | 1 | First X-bit is on `ohData` |

## Verification
On the first X-bit, three things coincide in one cycle: the frame-start marker, the overhead-bit indicator and the launch of the overhead frame marker. One cycle later, the overhead sample enable for that same bit fires while the full-rate path is already showing the next payload bit. Back-to-back strobes provoke this overlap. The scoreboard judges each path against its own queue: the full-rate queue is checked on strobe-following cycles, and the overhead queue is popped only on enable pulses. A crossed or missing event therefore shows up as a mismatch or as a leftover item.

// File: rtl/rxoh_pkg.sv
package rxoh_pkg;
  typedef struct packed {
    logic take;
    logic isOh;
    logic isFirst;
    logic locked;
  } rxohCtl_t;
endpackage

// File: rtl/rxoh_ctrl.sv
module rxoh_ctrl
  import rxoh_pkg::*;
#(
  parameter int BLOCK_LEN  = 85,
  parameter int NUM_BLOCKS = 56,
  parameter int IDX_W      = 13
) (
  input  logic             inStrobe,
  input  logic             inLocked,
  input  logic [IDX_W-1:0] inBitIdx,
  output rxohCtl_t         ctl
);
  logic [NUM_BLOCKS-1:0] hitVec;

  // one comparator per block start position
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    assign hitVec[g] = (inBitIdx == IDX_W'(g * BLOCK_LEN));
  end

  always_comb begin
    ctl.take    = inStrobe;
    ctl.isOh    = |hitVec;
    ctl.isFirst = hitVec[0];
    ctl.locked  = inLocked;
  end
endmodule

// File: rtl/rxoh_dp.sv
module rxoh_dp
  import rxoh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inBit,
  input  logic     inLocked,
  input  rxohCtl_t ctl,
  output logic     serData,
  output logic     ohInd,
  output logic     frameStart,
  output logic     ohData,
  output logic     ohClkEn,
  output logic     ohFrame
);
  logic launchPending;
  logic ohTake;

  assign ohTake = ctl.take & ctl.isOh & ctl.locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serData       <= 1'b0;
      ohInd         <= 1'b0;
      frameStart    <= 1'b0;
      ohData        <= 1'b0;
      ohClkEn       <= 1'b0;
      ohFrame       <= 1'b0;
      launchPending <= 1'b0;
    end else begin
      ohInd      <= 1'b0;
      frameStart <= 1'b0;
      if (ctl.take) begin
        serData    <= inBit;
        ohInd      <= ctl.isOh & ctl.locked;
        frameStart <= ctl.isFirst & ctl.locked;
      end
      // launch data one cycle ahead of its sample enable
      launchPending <= ohTake;
      if (ohTake) begin
        ohData  <= inBit;
        ohFrame <= ctl.isFirst;
      end else if (!inLocked) begin
        ohFrame <= 1'b0;
      end
      ohClkEn <= launchPending & inLocked;
    end
  end
endmodule

// File: rtl/rxoh_port.sv
module rxoh_port
  import rxoh_pkg::*;
#(
  parameter int BLOCK_LEN  = 85,
  parameter int NUM_BLOCKS = 56,
  parameter int IDX_W      = $clog2(BLOCK_LEN * NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inBit,
  input  logic             inStrobe,
  input  logic             inLocked,
  input  logic [IDX_W-1:0] inBitIdx,
  output logic             serData,
  output logic             ohInd,
  output logic             frameStart,
  output logic             ohData,
  output logic             ohClkEn,
  output logic             ohFrame
);
  rxohCtl_t ctl;

  rxoh_ctrl #(
    .BLOCK_LEN (BLOCK_LEN),
    .NUM_BLOCKS(NUM_BLOCKS),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .inStrobe(inStrobe),
    .inLocked(inLocked),
    .inBitIdx(inBitIdx),
    .ctl     (ctl)
  );

  rxoh_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inBit     (inBit),
    .inLocked  (inLocked),
    .ctl       (ctl),
    .serData   (serData),
    .ohInd     (ohInd),
    .frameStart(frameStart),
    .ohData    (ohData),
    .ohClkEn   (ohClkEn),
    .ohFrame   (ohFrame)
  );
endmodule

// File: rtl/rxoh_port_chk.sv
module rxoh_port_chk (
  input logic clk,
  input logic rstN,
  input logic inStrobe,
  input logic inLocked,
  input logic serData,
  input logic ohInd,
  input logic frameStart,
  input logic ohData,
  input logic ohClkEn,
  input logic ohFrame
);
  // R2
  ohind_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ohInd |=> !ohInd);
  // R3
  frame_with_oh_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> ohInd);
  // R4
  ohclk_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ohClkEn |=> !ohClkEn);
  // R4
  ohdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ohClkEn |-> $stable(ohData));
  // R4
  ohclk_after_ind_chk: assert property (@(posedge clk) disable iff (!rstN)
    ohClkEn |-> $past(ohInd));
  // R6
  ohframe_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ohClkEn && ohFrame) |-> $past(frameStart));
  // R7
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inLocked) |-> (!ohInd && !frameStart && !ohClkEn));
  // R9
  ind_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ohInd || frameStart) |-> $past(inStrobe));
endmodule

bind rxoh_port rxoh_port_chk u_chk (.*);

// File: tb/rxoh_port_bench.sv
module rxoh_port_bench;
  localparam int HALF = 4;
  localparam int MLEN = 4760;
  localparam int BLEN = 85;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inBit = 1'b0, inStrobe = 1'b0, inLocked = 1'b0;
  logic [12:0] inBitIdx = '0;
  logic serData, ohInd, frameStart, ohData, ohClkEn, ohFrame;

  int checks = 0, failures = 0;
  bit [2:0] serQ[$];
  bit [1:0] ohQ[$];
  bit stbD = 1'b0;
  bit lastSer = 1'b0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int idx = 4700;

  always #HALF clk = ~clk;

  rxoh_port u_rxoh_port (.*);

  always @(posedge clk) stbD <= inStrobe;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: one bit then `gap` idle cycles
  task automatic sendBit(input bit lk, input int gap);
    bit b, isOh;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
    isOh = (idx % BLEN) == 0;
    @(posedge clk); #1;
    inBit = b; inStrobe = 1'b1; inLocked = lk; inBitIdx = 13'(idx);
    serQ.push_back({b, isOh && lk, (idx == 0) && lk});
    if (isOh && lk) ohQ.push_back({b, idx == 0});
    idx = (idx + 1) % MLEN;
    for (int k = 0; k < gap; k++) begin
      @(posedge clk); #1;
      inStrobe = 1'b0;
    end
    if (gap == 0) ; else inStrobe = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (monOn) begin
      if (stbD) begin
        bit [2:0] e;
        if (serQ.size() == 0) chk(0, "R1", 1, 0);
        else begin
          e = serQ.pop_front();
          chk(serData == e[2], "R1", serData, e[2]);
          chk(ohInd == e[1], "R2", ohInd, e[1]);
          chk(frameStart == e[0], "R3", frameStart, e[0]);
          lastSer = e[2];
        end
      end else begin
        chk(serData == lastSer, "R1", serData, lastSer);
        chk(!ohInd && !frameStart, "R9", {ohInd, frameStart}, 0);
      end
      if (ohClkEn) begin
        bit [1:0] o;
        if (ohQ.size() == 0) chk(0, "R7", 1, 0);
        else begin
          o = ohQ.pop_front();
          chk(ohData == o[1], "R4/R5", ohData, o[1]);
          chk(ohFrame == o[0], "R6", ohFrame, o[0]);
        end
      end
    end
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk({serData, ohInd, frameStart, ohData, ohClkEn, ohFrame} == 6'b0, "R8",
        {serData, ohInd, frameStart, ohData, ohClkEn, ohFrame}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    monOn = 1'b1;
    // R7: unlocked across an M-frame boundary
    for (int n = 0; n < 181; n++) sendBit(1'b0, 0);
    // R2 R3 R5: two locked M-frames, back-to-back strobes
    for (int n = 0; n < 2 * MLEN; n++) sendBit(1'b1, 0);
    // R9: spaced strobes over one M-frame
    for (int n = 0; n < MLEN; n++) sendBit(1'b1, n % 3);
    // R7: drop lock mid-block, then relock
    for (int n = 0; n < 100; n++) sendBit(1'b0, 1);
    for (int n = 0; n < 400; n++) sendBit(1'b1, 0);
    @(posedge clk); #1 inStrobe = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R5: every expected overhead bit was delivered
    chk(ohQ.size() == 0, "R5", ohQ.size(), 0);
    chk(serQ.size() == 0, "R1", serQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule